// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a synchronous static memory whose word is made of eight 9-bit lanes. It takes address, direction and lane enables at each rising clock edge. Reads and writes may alternate on every cycle with no idle cycle between them. To allow this, write data does not come with its command. It arrives on the data bus a fixed number of cycles later: two cycles in pipelined mode and one cycle in flow-through mode. In pipelined mode read data passes through an output register. In flow-through mode it comes straight from the array one cycle earlier.

A read can follow a write to the same location while that write's data is still in flight. In that case the read takes the in-flight lanes from the bus and the remaining lanes from the array. Three chip enables must all be active for a cycle to start an access. An active-low output enable turns the data drivers off at once, whatever the clock is doing. Each written lane is checked for parity, even or odd as selected, and a single-cycle flag reports a mismatch.

Top module: `lw_sram`

## Requirements
- R1: Address, direction, lane enables, chip enables and write data are sampled only at the rising edge of `clk`. A read returns the most recent data written to that address by earlier commands.
- R2: With `pipe_mode`=1, a read sampled at edge N drives its data on `dq` with `dq_drive`=1 in the cycle that starts at edge N+1.
- R3: With `pipe_mode`=0, a read sampled at edge N drives its data on `dq` with `dq_drive`=1 in the cycle that starts at edge N itself.
- R4: For a write sampled at edge N, data on `wdata` is taken at edge N+2 when `pipe_mode`=1, and at edge N+1 when `pipe_mode`=0. Bus values at other edges are ignored.
- R5: Reads and writes may be issued on consecutive cycles in any order. The output slot that belongs to a write command leaves `dq_drive`=0.
- R6: In pipelined mode, a read to the address of the write issued one cycle earlier returns that write's enabled lanes from the bus. It returns the other lanes from the array.
- R7: `lane_we[i]` enables lane i, which is bits 9*i+8 down to 9*i of the word. Lanes whose enable is clear keep their old contents.
- R8: An access starts only when `en_a`=1, `en_b_n`=0 and `en_c`=1. If any one of them is inactive, a write command stores nothing.
- R9: A deselected cycle leaves `dq_drive`=0 in the output slot that a read would have used.
- R10: `out_en_n`=1 forces `dq_drive`=0 and `dq` to high impedance at once, without waiting for a clock edge.
- R11: Bit 9*i+8 is the parity bit of lane i. A lane passes when the XOR of its nine bits equals `odd_par` (0 selects even, 1 selects odd). `par_err` is 1 for the one cycle after the edge that takes the write data, if any enabled lane fails.
- R12: While `rst_n`=0, `dq_drive` and `par_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| pipe_mode | input | 1 | 1 selects pipelined mode, 0 selects flow-through mode (static) |
| odd_par | input | 1 | 1 selects odd lane parity, 0 selects even (static) |
| en_a | input | 1 | Chip enable, active high |
| en_b_n | input | 1 | Chip enable, active low |
| en_c | input | 1 | Chip enable, active high |
| wr_req | input | 1 | 1 means write, 0 means read |
| addr | input | ADDR_W | Word address |
| lane_we | input | NBYTES | Per-lane write enables |
| wdata | input | NBYTES*BYTE_W | Late write data bus |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| dq | output | NBYTES*BYTE_W | Read data, high impedance when not driving |
| dq_drive | output | 1 | High while `dq` is driven |
| par_err | output | 1 | Lane parity mismatch flag, one cycle per write |

## Verification
The properties assume that `pipe_mode` and `odd_par` hold steady for as long as any command is in flight. Their latency windows count edges in one mode only. The stimulus therefore changes either input only after several deselected cycles, once both the read slots and the write slots have drained. The properties also take `out_en_n` as an input that can change mid-cycle. The bench moves it between edges and probes `dq_drive` before the next edge.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

    localparam int LW_DEF_ADDR_W = 4;
    localparam int LW_DEF_NBYTES = 8;
    localparam int LW_DEF_BYTE_W = 9;

    typedef enum logic {
        MODE_FLOW = 1'b0,
        MODE_PIPE = 1'b1
    } lw_mode_e;

endpackage

// File: rtl/lw_cmd_pipe.sv
module lw_cmd_pipe #(
    parameter int ADDR_W = 4,
    parameter int NBYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              is_write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NBYTES-1:0] lanes,
    output logic              s1_rd,
    output logic              s1_wr,
    output logic [ADDR_W-1:0] s1_addr,
    output logic [NBYTES-1:0] s1_lanes,
    output logic              s2_wr,
    output logic [ADDR_W-1:0] s2_addr,
    output logic [NBYTES-1:0] s2_lanes
);

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [NBYTES-1:0] lanes;
    } stage1_t;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [NBYTES-1:0] lanes;
    } stage2_t;

    typedef struct packed {
        stage1_t s1;
        stage2_t s2;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d          = pipe_q;
        pipe_d.s1.rd    = issue & ~is_write;
        pipe_d.s1.wr    = issue & is_write;
        pipe_d.s1.addr  = addr;
        pipe_d.s1.lanes = lanes;
        pipe_d.s2.wr    = pipe_q.s1.wr;
        pipe_d.s2.addr  = pipe_q.s1.addr;
        pipe_d.s2.lanes = pipe_q.s1.lanes;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign s1_rd    = pipe_q.s1.rd;
    assign s1_wr    = pipe_q.s1.wr;
    assign s1_addr  = pipe_q.s1.addr;
    assign s1_lanes = pipe_q.s1.lanes;
    assign s2_wr    = pipe_q.s2.wr;
    assign s2_addr  = pipe_q.s2.addr;
    assign s2_lanes = pipe_q.s2.lanes;

endmodule

// File: rtl/lw_store.sv
module lw_store #(
    parameter int ADDR_W = 4,
    parameter int NBYTES = 8,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [NBYTES-1:0]        wr_lanes,
    input  logic [NBYTES*BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [NBYTES*BYTE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_lanes[g]) cells[wr_addr] <= wr_data[g*BYTE_W +: BYTE_W];
        end

        assign rd_data[g*BYTE_W +: BYTE_W] = cells[rd_addr];
    end

endmodule

// File: rtl/lw_par_check.sv
module lw_par_check #(
    parameter int NBYTES = 8,
    parameter int BYTE_W = 9
) (
    input  logic [NBYTES*BYTE_W-1:0] data,
    input  logic [NBYTES-1:0]        lanes,
    input  logic                     odd,
    output logic                     bad_any
);

    logic [NBYTES-1:0] bad_lane;

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign bad_lane[g] = lanes[g] & ((^data[g*BYTE_W +: BYTE_W]) != odd);
    end

    assign bad_any = |bad_lane;

endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = LW_DEF_ADDR_W,
    parameter int NBYTES = LW_DEF_NBYTES,
    parameter int BYTE_W = LW_DEF_BYTE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pipe_mode,
    input  logic                     odd_par,
    input  logic                     en_a,
    input  logic                     en_b_n,
    input  logic                     en_c,
    input  logic                     wr_req,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NBYTES-1:0]        lane_we,
    input  logic [NBYTES*BYTE_W-1:0] wdata,
    input  logic                     out_en_n,
    output logic [NBYTES*BYTE_W-1:0] dq,
    output logic                     dq_drive,
    output logic                     par_err
);

    localparam int WORD_W = NBYTES * BYTE_W;

    lw_mode_e mode;
    logic     is_pipe;
    logic     issue;

    assign mode    = lw_mode_e'(pipe_mode);
    assign is_pipe = (mode == MODE_PIPE);
    assign issue   = en_a & ~en_b_n & en_c;

    logic              s1_rd, s1_wr, s2_wr;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    logic [NBYTES-1:0] s1_lanes, s2_lanes;

    lw_cmd_pipe #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) cmd_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (issue),
        .is_write (wr_req),
        .addr     (addr),
        .lanes    (lane_we),
        .s1_rd    (s1_rd),
        .s1_wr    (s1_wr),
        .s1_addr  (s1_addr),
        .s1_lanes (s1_lanes),
        .s2_wr    (s2_wr),
        .s2_addr  (s2_addr),
        .s2_lanes (s2_lanes)
    );

    // Commit point: the stage whose write data is on the bus this cycle.
    logic              cm_wr;
    logic [ADDR_W-1:0] cm_addr;
    logic [NBYTES-1:0] cm_lanes;

    assign cm_wr    = is_pipe ? s2_wr    : s1_wr;
    assign cm_addr  = is_pipe ? s2_addr  : s1_addr;
    assign cm_lanes = is_pipe ? s2_lanes : s1_lanes;

    logic [WORD_W-1:0] arr_word;

    lw_store #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) store_i (
        .clk      (clk),
        .wr_en    (cm_wr),
        .wr_addr  (cm_addr),
        .wr_lanes (cm_lanes),
        .wr_data  (wdata),
        .rd_addr  (s1_addr),
        .rd_data  (arr_word)
    );

    logic cm_bad;

    lw_par_check #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) par_i (
        .data    (wdata),
        .lanes   (cm_lanes & {NBYTES{cm_wr}}),
        .odd     (odd_par),
        .bad_any (cm_bad)
    );

    // Pending-write forwarding: only the pipelined mode leaves a write
    // uncommitted while a younger read looks at the array.
    logic              fwd_hit;
    logic [WORD_W-1:0] rd_word;

    assign fwd_hit = is_pipe & s2_wr & (s2_addr == s1_addr);

    for (genvar g = 0; g < NBYTES; g++) begin : g_merge
        assign rd_word[g*BYTE_W +: BYTE_W] = (fwd_hit && s2_lanes[g])
                                           ? wdata[g*BYTE_W +: BYTE_W]
                                           : arr_word[g*BYTE_W +: BYTE_W];
    end

    typedef struct packed {
        logic              drv;
        logic [WORD_W-1:0] word;
        logic              perr;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d      = out_q;
        out_d.drv  = s1_rd;
        out_d.perr = cm_wr & cm_bad;
        if (s1_rd) out_d.word = rd_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    logic              core_drv;
    logic [WORD_W-1:0] core_word;

    assign core_drv  = is_pipe ? out_q.drv  : s1_rd;
    assign core_word = is_pipe ? out_q.word : rd_word;

    assign dq_drive = core_drv & ~out_en_n;
    assign dq       = dq_drive ? core_word : {WORD_W{1'bz}};
    assign par_err  = out_q.perr;

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
    parameter int ADDR_W = 4,
    parameter int NBYTES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pipe_mode,
    input logic              en_a,
    input logic              en_b_n,
    input logic              en_c,
    input logic              wr_req,
    input logic [ADDR_W-1:0] addr,
    input logic [NBYTES-1:0] lane_we,
    input logic              out_en_n,
    input logic              dq_drive,
    input logic              par_err
);

    logic sel;
    assign sel = en_a & ~en_b_n & en_c;

    // R2: pipelined read occupies the slot two edges later
    a_r2_pipe_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && sel && !wr_req) |=> ##1 (dq_drive || out_en_n));

    // R3: flow-through read occupies the slot at the next edge
    a_r3_flow_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && sel && !wr_req) |=> (dq_drive || out_en_n));

    // R5: a write command leaves its output slot undriven
    a_r5_pipe_write_slot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && sel && wr_req) |=> ##1 !dq_drive);
    a_r5_flow_write_slot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && sel && wr_req) |=> !dq_drive);

    // R9: deselected cycles leave their slot undriven
    a_r9_pipe_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && !sel) |=> ##1 !dq_drive);
    a_r9_flow_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && !sel) |=> !dq_drive);

    // R10: output enable overrides at any time
    always_comb begin
        if (rst_n && out_en_n) begin
            a_r10_oe_forces_off: assert (!dq_drive);
        end
    end

    // R11: the flag only follows a selected write at the data-capture edge
    a_r11_pipe_perr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && par_err) |-> $past(sel && wr_req, 3));
    a_r11_flow_perr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && par_err) |-> $past(sel && wr_req, 2));

    // R12: reset keeps outputs quiet
    a_r12_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!par_err && !dq_drive));

    logic unused_ok;
    assign unused_ok = ^{addr, lane_we};

endmodule

bind lw_sram lw_sram_chk #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_mode (pipe_mode),
    .en_a      (en_a),
    .en_b_n    (en_b_n),
    .en_c      (en_c),
    .wr_req    (wr_req),
    .addr      (addr),
    .lane_we   (lane_we),
    .out_en_n  (out_en_n),
    .dq_drive  (dq_drive),
    .par_err   (par_err)
);

// File: tb/lw_sram_tb_top.sv
module lw_sram_tb_top;

    localparam int AW = 4;
    localparam int NB = 8;
    localparam int BW = 9;
    localparam int WW = NB * BW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pipe_mode = 1'b1;
    logic          odd_par = 1'b0;
    logic          en_a = 1'b0;
    logic          en_b_n = 1'b1;
    logic          en_c = 1'b0;
    logic          wr_req = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [NB-1:0] lane_we = '0;
    logic [WW-1:0] wdata = '0;
    logic          out_en_n = 1'b0;
    wire  [WW-1:0] dq;
    logic          dq_drive;
    logic          par_err;

    lw_sram #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(BW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .odd_par(odd_par),
        .en_a(en_a), .en_b_n(en_b_n), .en_c(en_c), .wr_req(wr_req),
        .addr(addr), .lane_we(lane_we), .wdata(wdata), .out_en_n(out_en_n),
        .dq(dq), .dq_drive(dq_drive), .par_err(par_err)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int            at;
        logic          drv;
        logic [WW-1:0] data;
        string         tag;
    } dq_exp_t;

    typedef struct {
        int    at;
        logic  err;
        string tag;
    } err_exp_t;

    dq_exp_t  dq_q[$];
    err_exp_t err_q[$];

    logic [WW-1:0] model [DEPTH];
    logic [WW-1:0] wsched [4];
    logic          wsched_v [4];

    int checks = 0;
    int fails = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] mkw(input int seed, input logic odd);
        logic [WW-1:0] w;
        for (int i = 0; i < NB; i++) begin
            logic [7:0] b;
            b = 8'(seed * 37 + i * 11 + 5);
            w[i*BW +: BW] = {(^b) ^ odd, b};
        end
        return w;
    endfunction

    function automatic logic lanes_bad(input logic [WW-1:0] d, input logic [NB-1:0] ln,
                                       input logic odd);
        logic bad;
        bad = 1'b0;
        for (int i = 0; i < NB; i++)
            if (ln[i] && ((^d[i*BW +: BW]) != odd)) bad = 1'b1;
        return bad;
    endfunction

    // Driver: kind 0 deselect, 1 read, 2 write, 3 deselected write attempt
    task automatic step(input int kind, input logic [AW-1:0] a, input logic [NB-1:0] ln,
                        input logic [WW-1:0] d, input string tag, input int drop = 0);
        int lat;
        dq_exp_t  de;
        err_exp_t ee;
        @(posedge clk);
        #5;
        if (wsched_v[cyc % 4]) begin
            wdata = wsched[cyc % 4];
            wsched_v[cyc % 4] = 1'b0;
        end else begin
            wdata = {$urandom, $urandom, $urandom};
        end
        lat = pipe_mode ? 2 : 1;
        en_a = 1'b1; en_b_n = 1'b0; en_c = 1'b1;
        addr = a; lane_we = ln;
        wr_req = (kind == 2 || kind == 3);
        if (kind == 0 || kind == 3) begin
            case (drop)
                0:       en_a = 1'b0;
                1:       en_b_n = 1'b1;
                default: en_c = 1'b0;
            endcase
        end
        ee.at = cyc + lat + 1; ee.err = 1'b0; ee.tag = tag;
        if (kind == 2) begin
            wsched[(cyc + lat) % 4]   = d;
            wsched_v[(cyc + lat) % 4] = 1'b1;
            for (int i = 0; i < NB; i++)
                if (ln[i]) model[a][i*BW +: BW] = d[i*BW +: BW];
            ee.err = lanes_bad(d, ln, odd_par);
        end
        err_q.push_back(ee);
        de.at = cyc + lat; de.drv = (kind == 1); de.data = model[a]; de.tag = tag;
        dq_q.push_back(de);
    endtask

    task automatic drain();
        for (int i = 0; i < 4; i++) step(0, '0, '0, '0, "R9 drain", i % 3);
        repeat (4) @(posedge clk);
    endtask

    // Monitor: compares outputs against the scoreboard away from the edge
    always @(negedge clk) begin : mon
        dq_exp_t  e;
        err_exp_t f;
        logic     xd;
        if (rst_n) begin
            while (dq_q.size() > 0 && dq_q[0].at <= cyc) begin
                e = dq_q.pop_front();
                xd = e.drv & ~out_en_n;
                if (e.at < cyc) check(1'b0, e.tag, "dq slot missed", WW'(cyc), WW'(e.at));
                else begin
                    check(dq_drive === xd, e.tag, "dq_drive", WW'(dq_drive), WW'(xd));
                    if (xd) check(dq === e.data, e.tag, "dq data", dq, e.data);
                end
            end
            while (err_q.size() > 0 && err_q[0].at <= cyc) begin
                f = err_q.pop_front();
                if (f.at < cyc) check(1'b0, f.tag, "err slot missed", WW'(cyc), WW'(f.at));
                else check(par_err === f.err, f.tag, "par_err", WW'(par_err), WW'(f.err));
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog act=timeout exp=finish");
            summary();
            $finish;
        end
    end

    initial begin : stim
        logic [WW-1:0] w;
        for (int i = 0; i < 4; i++) wsched_v[i] = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        // R12: reset state
        check(dq_drive === 1'b0, "R12", "dq_drive in reset", WW'(dq_drive), '0);
        check(par_err === 1'b0, "R12", "par_err in reset", WW'(par_err), '0);
        @(negedge clk);
        rst_n = 1'b1;

        // Pipelined, even parity: fill then read back (R1, R2, R4)
        for (int a = 0; a < DEPTH; a++) step(2, AW'(a), '1, mkw(a, 1'b0), "R4 pipe fill");
        for (int a = 0; a < DEPTH; a++) step(1, AW'(a), '0, '0, "R2 pipe read");

        // R5: alternating write/read, different addresses
        for (int k = 0; k < 6; k++) begin
            step(2, AW'(k), '1, mkw(100 + k, 1'b0), "R5 alt write");
            step(1, AW'(k + 8), '0, '0, "R5 alt read");
        end
        // R6 and R7: read right behind a partial write to the same address
        step(2, 4'd3, 8'b1010_0101, mkw(200, 1'b0), "R6 fwd write");
        step(1, 4'd3, '0, '0, "R6 fwd read");
        step(1, 4'd3, '0, '0, "R7 lanes after commit");
        step(2, 4'd9, 8'b0000_0001, mkw(201, 1'b0), "R7 single lane");
        step(2, 4'd9, 8'b1000_0000, mkw(202, 1'b0), "R7 top lane");
        step(1, 4'd9, '0, '0, "R6 fwd over commit");

        // R8, R9: each chip enable blocks a write attempt
        for (int c = 0; c < 3; c++) begin
            step(3, 4'd5, '1, mkw(300 + c, 1'b0), "R8 blocked write", c);
            step(0, 4'd5, '0, '0, "R9 desel", c);
            step(1, 4'd5, '0, '0, "R8 unchanged");
        end

        // R10: asynchronous output enable while reads stream
        step(1, 4'd1, '0, '0, "R10 stream");
        step(1, 4'd2, '0, '0, "R10 stream");
        step(1, 4'd4, '0, '0, "R10 stream");
        #7;
        out_en_n = 1'b1;
        #1;
        check(dq_drive === 1'b0, "R10", "drive with oe off", WW'(dq_drive), '0);
        out_en_n = 1'b0;
        #1;
        check(dq_drive === 1'b1, "R10", "drive restored", WW'(dq_drive), WW'(1));

        // R11: parity, even then odd
        w = mkw(400, 1'b0);
        w[BW] = ~w[BW];
        step(2, 4'd6, '1, w, "R11 even bad lane");
        step(2, 4'd7, 8'b1111_1101, w, "R11 bad lane disabled");
        step(1, 4'd6, '0, '0, "R11 bad data still stored");
        drain();
        odd_par = 1'b1;
        step(2, 4'd6, '1, mkw(410, 1'b1), "R11 odd good");
        step(2, 4'd7, '1, mkw(411, 1'b0), "R11 odd sees even word");
        step(1, 4'd7, '0, '0, "R11 readback");

        // Flow-through mode (R3, R4, R5)
        drain();
        pipe_mode = 1'b0;
        for (int a = 0; a < 4; a++) step(2, AW'(a), '1, mkw(500 + a, 1'b1), "R4 flow write");
        for (int a = 0; a < 4; a++) step(1, AW'(a), '0, '0, "R3 flow read");
        for (int k = 0; k < 5; k++) begin
            step(2, AW'(k + 10), 8'b0011_1100, mkw(600 + k, 1'b1), "R5 flow alt write");
            step(1, AW'(k + 10), '0, '0, "R5 flow read-after-write");
        end
        w = mkw(700, 1'b1);
        w[0] = ~w[0];
        step(2, 4'd2, '1, w, "R11 flow bad lane");
        step(0, 4'd2, '0, '0, "R9 flow desel", 1);
        step(1, 4'd2, '0, '0, "R1 flow readback");
        drain();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule